// File: doc/BRIEF.md
# RV32I Integer Execution Unit with Decode

This block is a purely combinational integer execution stage for the two 32-bit arithmetic instruction groups: register-register (major opcode `0110011`) and register-immediate (major opcode `0010011`). It receives the raw instruction word and the two source operand values that a register file has already read. From those it decodes the operation, extends the immediate and computes the result.

It produces three kinds of output. The first is the 32-bit result. The second is a destination write strobe. The third is a pair of mutually exclusive flags: one for an encoding inside the two groups that no operation defines, and one for an instruction that belongs to neither group.

The block is meant to sit between operand read and writeback in a simple pipeline. The surrounding pipeline routes `result_o` to the destination index held in instruction bits 11:7 whenever `rd_we_o` is high. It raises a trap when `illegal_o` is high. It hands the instruction to another unit when `foreign_o` is high.

Top module: `rv_int_alu`

## Requirements
- R1: In the register group, instruction bits 14:12 pick the operation: 000 add or subtract, 001 left shift, 010 signed less-than, 011 unsigned less-than, 100 XOR, 101 right shift, 110 OR, 111 AND. With 000, bits 31:25 equal to 0100000 select rs1 minus rs2, and 0000000 selects rs1 plus rs2.
- R2: Add and subtract wrap modulo 2^32, and no overflow is flagged.
- R3: Register shifts use only rs2 bits 4:0 as the amount. In the 101 group, 0000000 in bits 31:25 gives a zero-filling right shift, and 0100000 gives a sign-filling right shift.
- R4: In the register group, bits 31:25 other than 0000000 raise `illegal_o`. The exception is that 0100000 is also legal for the 000 and 101 selections.
- R5: In the immediate group, bits 31:20 are sign-extended to 32 bits and replace rs2 under the same bits 14:12 mapping. There is no immediate subtract, so the upper immediate bits never turn an add into a subtract.
- R6: The immediate signed less-than compares as signed values. The immediate unsigned less-than first sign-extends the immediate and then compares as unsigned values, so an immediate of 1 yields 1 exactly when rs1 is zero.
- R7: Immediate shifts take the amount from instruction bits 24:20. Bit 30 set, with bits 31:25 equal to 0100000, selects the sign-filling right shift.
- R8: The immediate left shift requires bits 31:25 to be 0000000. The immediate right shifts require 0000000 or 0100000. Any other value raises `illegal_o`.
- R9: Both less-than operations return exactly 1 when the comparison holds and 0 otherwise.
- R10: `rd_we_o` is high only for a legal instruction of either group whose destination field (bits 11:7) is nonzero. With destination 0 the result is still computed, but no write is requested.
- R11: An instruction whose bits 6:0 match neither group gives `foreign_o` = 1, `illegal_o` = 0, `rd_we_o` = 0 and a zero result.
- R12: When `illegal_o` is high, the result is zero and `rd_we_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| src_a_i | input | 32 | First source operand (rs1 value) |
| src_b_i | input | 32 | Second source operand (rs2 value), unused for the immediate group |
| result_o | output | 32 | Operation result, zero when illegal or foreign |
| rd_we_o | output | 1 | Destination write request |
| illegal_o | output | 1 | Undefined encoding within the two groups |
| foreign_o | output | 1 | Instruction belongs to neither group |

## Verification
Two functions can act on the same instruction: illegal-encoding detection and the suppression of writes to destination 0. Each of them alone clears `rd_we_o`, so the bench drives encodings that trip both at once. One case is a register add with a bad upper field aimed at destination 0. The check confirms that the illegal flag still rises and that the result is still forced to zero, and that the two mechanisms do not mask each other. The opposite case, a legal operation aimed at destination 0, must still show the computed result with no write request. Together these two cases show that the zero-destination rule affects only the strobe.

// File: rtl/rvalu_pkg.sv
package rvalu_pkg;

  localparam logic [6:0] OPC_REG = 7'b0110011;
  localparam logic [6:0] OPC_IMM = 7'b0010011;
  localparam logic [6:0] F7_BASE = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;

  typedef enum logic [3:0] {
    OPK_ADD, OPK_SUB, OPK_SLL, OPK_SLT, OPK_SLTU,
    OPK_XOR, OPK_SRL, OPK_SRA, OPK_OR,  OPK_AND
  } alu_op_e;

endpackage

// File: rtl/rvalu_decode.sv
module rvalu_decode
  import rvalu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IMMW = 12
) (
  input  logic [6:0]      opc_i,
  input  logic [2:0]      f3_i,
  input  logic [IMMW-1:0] imm_field_i,
  output logic            grp_reg_o,
  output logic            grp_imm_o,
  output logic            bad_o,
  output alu_op_e         op_o,
  output logic [XLEN-1:0] imm_o
);

  localparam int EXTW = XLEN - IMMW;

  logic [6:0] f7;
  logic       f7_base;
  logic       f7_alt;
  logic       bad_raw;

  assign f7        = imm_field_i[IMMW-1 -: 7];
  assign f7_base   = (f7 == F7_BASE);
  assign f7_alt    = (f7 == F7_ALT);
  assign grp_reg_o = (opc_i == OPC_REG);
  assign grp_imm_o = (opc_i == OPC_IMM);
  assign imm_o     = {{EXTW{imm_field_i[IMMW-1]}}, imm_field_i};

  always_comb begin
    op_o    = OPK_ADD;
    bad_raw = 1'b0;
    unique case (f3_i)
      3'b000: begin
        op_o    = (grp_reg_o && f7_alt) ? OPK_SUB : OPK_ADD;
        bad_raw = grp_reg_o && !(f7_base || f7_alt);
      end
      3'b001: begin
        op_o    = OPK_SLL;
        bad_raw = !f7_base;
      end
      3'b010: begin
        op_o    = OPK_SLT;
        bad_raw = grp_reg_o && !f7_base;
      end
      3'b011: begin
        op_o    = OPK_SLTU;
        bad_raw = grp_reg_o && !f7_base;
      end
      3'b100: begin
        op_o    = OPK_XOR;
        bad_raw = grp_reg_o && !f7_base;
      end
      3'b101: begin
        op_o    = f7_alt ? OPK_SRA : OPK_SRL;
        bad_raw = !(f7_base || f7_alt);
      end
      3'b110: begin
        op_o    = OPK_OR;
        bad_raw = grp_reg_o && !f7_base;
      end
      default: begin
        op_o    = OPK_AND;
        bad_raw = grp_reg_o && !f7_base;
      end
    endcase
  end

  assign bad_o = bad_raw && (grp_reg_o || grp_imm_o);

endmodule

// File: rtl/rvalu_shift.sv
module rvalu_shift #(
  parameter int XLEN = 32,
  parameter int SHW  = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] val_i,
  input  logic [SHW-1:0]  amt_i,
  input  logic            left_i,
  input  logic            arith_i,
  output logic [XLEN-1:0] val_o
);

  function automatic logic [XLEN-1:0] shr_fill(input logic [XLEN-1:0] v,
                                               input logic [SHW-1:0] n,
                                               input logic fill);
    logic [2*XLEN-1:0] wide;
    wide = {{XLEN{fill}}, v} >> n;
    return wide[XLEN-1:0];
  endfunction

  assign val_o = left_i ? (val_i << amt_i)
                        : shr_fill(val_i, amt_i, arith_i & val_i[XLEN-1]);

endmodule

// File: rtl/rvalu_exec.sv
module rvalu_exec
  import rvalu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [XLEN-1:0] shifted_i,
  output logic [XLEN-1:0] y_o
);

  function automatic logic lt_signed(input logic [XLEN-1:0] x, input logic [XLEN-1:0] y);
    return (x[XLEN-1] != y[XLEN-1]) ? x[XLEN-1] : (x < y);
  endfunction

  function automatic logic [XLEN-1:0] as_flag(input logic f);
    return {{(XLEN-1){1'b0}}, f};
  endfunction

  always_comb begin
    unique case (op_i)
      OPK_ADD:  y_o = a_i + b_i;
      OPK_SUB:  y_o = a_i - b_i;
      OPK_SLT:  y_o = as_flag(lt_signed(a_i, b_i));
      OPK_SLTU: y_o = as_flag(a_i < b_i);
      OPK_XOR:  y_o = a_i ^ b_i;
      OPK_OR:   y_o = a_i | b_i;
      OPK_AND:  y_o = a_i & b_i;
      default:  y_o = shifted_i;
    endcase
  end

endmodule

// File: rtl/rv_int_alu.sv
module rv_int_alu
  import rvalu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] src_a_i,
  input  logic [XLEN-1:0] src_b_i,
  output logic [XLEN-1:0] result_o,
  output logic            rd_we_o,
  output logic            illegal_o,
  output logic            foreign_o
);

  localparam int SHW = $clog2(XLEN);

  logic            grp_reg;
  logic            grp_imm;
  logic            enc_bad;
  alu_op_e         op_sel;
  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] opnd_b;
  logic [XLEN-1:0] shift_out;
  logic [XLEN-1:0] exec_out;
  logic            claimed;
  logic            accepted;
  logic            rd_zero;

  rvalu_decode #(.XLEN(XLEN), .IMMW(12)) u_dec (
    .opc_i       (instr_i[6:0]),
    .f3_i        (instr_i[14:12]),
    .imm_field_i (instr_i[31:20]),
    .grp_reg_o   (grp_reg),
    .grp_imm_o   (grp_imm),
    .bad_o       (enc_bad),
    .op_o        (op_sel),
    .imm_o       (imm_ext)
  );

  assign opnd_b = grp_imm ? imm_ext : src_b_i;

  rvalu_shift #(.XLEN(XLEN), .SHW(SHW)) u_shf (
    .val_i   (src_a_i),
    .amt_i   (opnd_b[SHW-1:0]),
    .left_i  (op_sel == OPK_SLL),
    .arith_i (op_sel == OPK_SRA),
    .val_o   (shift_out)
  );

  rvalu_exec #(.XLEN(XLEN)) u_exe (
    .op_i      (op_sel),
    .a_i       (src_a_i),
    .b_i       (opnd_b),
    .shifted_i (shift_out),
    .y_o       (exec_out)
  );

  assign claimed   = grp_reg || grp_imm;
  assign accepted  = claimed && !enc_bad;
  assign rd_zero   = (instr_i[11:7] == 5'd0);
  assign result_o  = accepted ? exec_out : '0;
  assign rd_we_o   = accepted && !rd_zero;
  assign illegal_o = enc_bad;
  assign foreign_o = !claimed;

endmodule

// File: rtl/rvalu_chk.sv
module rvalu_chk
  import rvalu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic [31:0]     instr_i,
  input logic [XLEN-1:0] result_o,
  input logic            rd_we_o,
  input logic            illegal_o,
  input logic            foreign_o,
  input alu_op_e         op_sel
);

  always_comb begin
    a_r10_we_needs_legal_dest: assert (!rd_we_o || (!illegal_o && !foreign_o && instr_i[11:7] != 5'd0))
      else $error("write request without legal nonzero destination");
    a_r11_flags_exclusive: assert (!(illegal_o && foreign_o))
      else $error("illegal and foreign both high");
    a_r11_foreign_quiet: assert (!foreign_o || (result_o == '0 && !rd_we_o))
      else $error("foreign instruction produced output");
    a_r12_illegal_zero: assert (!illegal_o || (result_o == '0 && !rd_we_o))
      else $error("illegal instruction produced output");
    a_r9_compare_boolean: assert (!((op_sel == OPK_SLT || op_sel == OPK_SLTU) && !foreign_o)
                                  || result_o[XLEN-1:1] == '0)
      else $error("compare result not 0 or 1");
  end

endmodule

bind rv_int_alu rvalu_chk #(.XLEN(XLEN)) u_chk (
  .instr_i   (instr_i),
  .result_o  (result_o),
  .rd_we_o   (rd_we_o),
  .illegal_o (illegal_o),
  .foreign_o (foreign_o),
  .op_sel    (op_sel)
);

// File: tb/tb_rv_int_alu.sv
module tb_rv_int_alu;

  localparam int CLK_P    = 10;
  localparam int WD_LIMIT = 20000;
  localparam logic [6:0] OR_ = 7'b0110011;
  localparam logic [6:0] OI_ = 7'b0010011;

  typedef struct {
    string       tag;
    logic [31:0] res;
    logic        we;
    logic        ill;
    logic        frn;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic [31:0] res;
  logic        we, ill, frn;
  item_t       sb[$];
  int          n_run = 0;
  int          n_fail = 0;
  int          cyc = 0;
  bit          done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rv_int_alu dut (
    .instr_i(instr), .src_a_i(a), .src_b_i(b),
    .result_o(res), .rd_we_o(we), .illegal_o(ill), .foreign_o(frn)
  );

  function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [2:0] f3, input logic [4:0] rd);
    return {f7, 5'd2, 5'd1, f3, rd, OR_};
  endfunction

  function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [2:0] f3, input logic [4:0] rd);
    return {imm, 5'd1, f3, rd, OI_};
  endfunction

  // independent reference written from the requirements
  function automatic item_t model(input string tag, input logic [31:0] ins,
                                  input logic [31:0] x, input logic [31:0] y);
    item_t e;
    logic [6:0]  f7 = ins[31:25];
    logic [2:0]  f3 = ins[14:12];
    logic        isr = (ins[6:0] == OR_);
    logic        isi = (ins[6:0] == OI_);
    logic [31:0] opb;
    int          sh;
    logic        upper_ok;
    e.tag = tag;
    if (!isr && !isi) begin
      e.res = 0; e.we = 0; e.ill = 0; e.frn = 1;
      return e;
    end
    e.frn = 0;
    opb = isr ? y : 32'($signed(ins[31:20]));
    sh  = int'(opb % 32);
    upper_ok = (f7 == 7'd0) || (f7 == 7'h20);
    if (isr) e.ill = (f3 == 3'd0 || f3 == 3'd5) ? !upper_ok : (f7 != 7'd0);
    else     e.ill = (f3 == 3'd1) ? (f7 != 7'd0) : (f3 == 3'd5) ? !upper_ok : 1'b0;
    case (f3)
      3'd0: e.res = (isr && f7 == 7'h20) ? x - opb : x + opb;
      3'd1: e.res = x << sh;
      3'd2: e.res = ($signed(x) < $signed(opb)) ? 32'd1 : 32'd0;
      3'd3: e.res = (x < opb) ? 32'd1 : 32'd0;
      3'd4: e.res = x ^ opb;
      3'd5: e.res = ins[30] ? 32'($signed(x) >>> sh) : x >> sh;
      3'd6: e.res = x | opb;
      default: e.res = x & opb;
    endcase
    if (e.ill) e.res = 0;
    e.we = !e.ill && (ins[11:7] != 5'd0);
    return e;
  endfunction

  task automatic drive(input string tag, input logic [31:0] ins,
                       input logic [31:0] x, input logic [31:0] y,
                       input logic [31:0] er, input logic ewe,
                       input logic eill, input logic efrn);
    item_t e;
    @(negedge clk);
    instr = ins; a = x; b = y;
    e.tag = tag; e.res = er; e.we = ewe; e.ill = eill; e.frn = efrn;
    sb.push_back(e);
  endtask

  task automatic drive_model(input string tag, input logic [31:0] ins,
                             input logic [31:0] x, input logic [31:0] y);
    @(negedge clk);
    instr = ins; a = x; b = y;
    sb.push_back(model(tag, ins, x, y));
  endtask

  // monitor: compare each queued item on the edge after it was driven
  always @(posedge clk) begin
    if (!rst && sb.size() > 0) begin
      item_t e;
      e = sb.pop_front();
      n_run++;
      if (res !== e.res || we !== e.we || ill !== e.ill || frn !== e.frn) begin
        n_fail++;
        $display("FAIL %s instr=%h a=%h b=%h: got res=%h we=%b ill=%b frn=%b, expected res=%h we=%b ill=%b frn=%b",
                 e.tag, instr, a, b, res, we, ill, frn, e.res, e.we, e.ill, e.frn);
      end
    end
  end

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got %0d cycles, expected at most %0d", cyc, WD_LIMIT);
      summary();
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11: idle word and another major opcode are foreign
    drive("R11", 32'h0, 32'h5, 32'h7, 32'h0, 0, 0, 1);
    drive("R11", {25'h12345, 7'b1101111}, 32'hFFFF_FFFF, 32'h1, 32'h0, 0, 0, 1);

    // R1: register group mapping
    drive("R1", enc_r(7'h00, 3'd0, 5'd3), 32'd5, 32'd7, 32'd12, 1, 0, 0);
    drive("R1", enc_r(7'h20, 3'd0, 5'd3), 32'd5, 32'd7, 32'hFFFF_FFFE, 1, 0, 0);
    drive("R1", enc_r(7'h00, 3'd4, 5'd3), 32'hF0F0_00FF, 32'h0FF0_0F0F, 32'hFF00_0FF0, 1, 0, 0);
    drive("R1", enc_r(7'h00, 3'd6, 5'd3), 32'hF000_0001, 32'h0000_1000, 32'hF000_1001, 1, 0, 0);
    drive("R1", enc_r(7'h00, 3'd7, 5'd3), 32'hF0F0_F0F0, 32'h3C3C_3C3C, 32'h3030_3030, 1, 0, 0);

    // R2: wraparound
    drive("R2", enc_r(7'h00, 3'd0, 5'd4), 32'h7FFF_FFFF, 32'd1, 32'h8000_0000, 1, 0, 0);
    drive("R2", enc_r(7'h00, 3'd0, 5'd4), 32'hFFFF_FFFF, 32'd1, 32'h0, 1, 0, 0);
    drive("R2", enc_r(7'h20, 3'd0, 5'd4), 32'h0, 32'd1, 32'hFFFF_FFFF, 1, 0, 0);

    // R3: only low 5 bits of rs2, fill kinds
    drive("R3", enc_r(7'h00, 3'd1, 5'd5), 32'd1, 32'h0000_0023, 32'd8, 1, 0, 0);
    drive("R3", enc_r(7'h20, 3'd5, 5'd5), 32'h8000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, 0);
    drive("R3", enc_r(7'h00, 3'd5, 5'd5), 32'h8000_0000, 32'h0000_003F, 32'h1, 1, 0, 0);

    // R4 / R12: bad upper field in register group
    drive("R4", enc_r(7'h01, 3'd0, 5'd6), 32'd5, 32'd7, 32'h0, 0, 1, 0);
    drive("R4", enc_r(7'h20, 3'd4, 5'd6), 32'd5, 32'd7, 32'h0, 0, 1, 0);
    drive("R12", enc_r(7'h40, 3'd7, 5'd6), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 0, 1, 0);

    // R5: sign-extended immediate, no immediate subtract
    drive("R5", enc_i(12'hFFF, 3'd0, 5'd7), 32'd10, 32'h0, 32'd9, 1, 0, 0);
    drive("R5", enc_i(12'h800, 3'd6, 5'd7), 32'h0, 32'h0, 32'hFFFF_F800, 1, 0, 0);
    drive("R5", enc_i(12'h405, 3'd0, 5'd7), 32'd1, 32'h0, 32'h0000_0406, 1, 0, 0);

    // R6: immediate compares
    drive("R6", enc_i(12'h001, 3'd2, 5'd8), 32'hFFFF_FFFB, 32'h0, 32'd1, 1, 0, 0);
    drive("R6", enc_i(12'h001, 3'd3, 5'd8), 32'h0, 32'h0, 32'd1, 1, 0, 0);
    drive("R6", enc_i(12'h001, 3'd3, 5'd8), 32'd5, 32'h0, 32'd0, 1, 0, 0);
    drive("R6", enc_i(12'hFFF, 3'd3, 5'd8), 32'd5, 32'h0, 32'd1, 1, 0, 0);

    // R7: immediate shifts
    drive("R7", enc_i({7'h20, 5'd4}, 3'd5, 5'd9), 32'h8000_0000, 32'h0, 32'hF800_0000, 1, 0, 0);
    drive("R7", enc_i({7'h00, 5'd4}, 3'd5, 5'd9), 32'h8000_0000, 32'h0, 32'h0800_0000, 1, 0, 0);
    drive("R7", enc_i({7'h00, 5'd31}, 3'd1, 5'd9), 32'h3, 32'h0, 32'h8000_0000, 1, 0, 0);

    // R8: bad upper field on immediate shifts
    drive("R8", enc_i({7'h20, 5'd1}, 3'd1, 5'd9), 32'h1, 32'h0, 32'h0, 0, 1, 0);
    drive("R8", enc_i({7'h01, 5'd1}, 3'd5, 5'd9), 32'h8, 32'h0, 32'h0, 0, 1, 0);

    // R9: compare outputs are 0 or 1
    drive("R9", enc_r(7'h00, 3'd2, 5'd10), 32'h8000_0000, 32'h1, 32'd1, 1, 0, 0);
    drive("R9", enc_r(7'h00, 3'd2, 5'd10), 32'h1, 32'h8000_0000, 32'd0, 1, 0, 0);
    drive("R9", enc_r(7'h00, 3'd3, 5'd10), 32'h1, 32'hFFFF_FFFF, 32'd1, 1, 0, 0);

    // R10: destination zero, alone and together with an illegal encoding
    drive("R10", enc_r(7'h00, 3'd0, 5'd0), 32'd5, 32'd7, 32'd12, 0, 0, 0);
    drive("R10", enc_r(7'h11, 3'd0, 5'd0), 32'd5, 32'd7, 32'h0, 0, 1, 0);

    // random traffic over both groups and some foreign opcodes
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ins = $urandom;
      logic [31:0] x = $urandom;
      logic [31:0] y = $urandom;
      int sel = $urandom_range(0, 9);
      if (sel < 4) begin
        ins[6:0] = OR_;
        ins[31:25] = ($urandom_range(0, 3) == 0) ? ins[31:25] : (ins[30] ? 7'h20 : 7'h00);
        drive_model("R1", ins, x, y);
      end else if (sel < 8) begin
        ins[6:0] = OI_;
        if (ins[14:12] == 3'd1 || ins[14:12] == 3'd5)
          ins[31:25] = ($urandom_range(0, 3) == 0) ? ins[31:25] : (ins[30] ? 7'h20 : 7'h00);
        drive_model("R5", ins, x, y);
      end else begin
        if (ins[6:0] == OR_ || ins[6:0] == OI_) ins[6:0] = 7'b0000011;
        drive_model("R11", ins, x, y);
      end
    end

    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      summary();
    end
  end

endmodule